// File: doc/BRIEF.md
# NAND Flash Strobe Timing Generator

This block times one data transfer on an asynchronous NAND flash device. A one-cycle request carries a direction flag and, for a write, one data word. The block then drives the bus enables one cycle early. It pulls the matching active-low strobe low for a programmed number of bus clock cycles, and keeps the buses driven for a programmed hold time after the strobe rises. At the end it reports completion with a single-cycle done pulse. On a read it also captures the data presented by the flash.

A 32-bit timing register holds two 4-bit fields. The pulse-width field sets how long the strobe stays low. A write strobe lasts exactly that many cycles, and a read strobe lasts one cycle longer. The hold field sets the hold time: the buses stay driven for one cycle more than the field value. Zero is not a valid setting for either field. If software writes zero, the block uses the value one. The fields are copied when a request is accepted, so a register write during a transfer only affects later transfers.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset the timing register reads 32'h0000_00FF, both strobes are high, both bus enables are low and done is low.
- R2: A register write stores bits 3:0 as the pulse-width field and bits 7:4 as the hold field. Bits 31:8 always read back as zero.
- R3: On a write transfer (req_rd=0), we_n is low for exactly the pulse-width value in cycles, re_n stays high, and bus_dout carries the request's write data for the whole transfer.
- R4: On a read transfer (req_rd=1), re_n is low for exactly the pulse-width value plus one cycles, and we_n stays high.
- R5: After the strobe rises, addr_oe stays high for the hold value plus one cycles and then falls.
- R6: A field value of zero behaves exactly as a value of one.
- R7: addr_oe rises exactly one cycle before the strobe falls.
- R8: done is high for one cycle, in the first cycle in which addr_oe is low after a transfer. A request that arrives while a transfer is running is ignored.
- R9: On a read, rd_data takes the value that bus_din had during the last cycle in which re_n was low, and keeps it until the next read.
- R10: A register write made during a running transfer does not change that transfer's timing. It applies from the next accepted request.
- R11: dat_oe is high during the whole window of a write transfer in which addr_oe is high, and it is never high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 32 | Timing register write data |
| cfg_rdata | output | 32 | Timing register read data |
| req | input | 1 | One-cycle transfer request |
| req_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| req_wdata | input | DW | Write data carried with the request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read data |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| addr_oe | output | 1 | Address bus drive enable |
| dat_oe | output | 1 | Data bus drive enable (write transfers only) |
| bus_dout | output | DW | Data driven onto the flash bus |
| bus_din | input | DW | Data returned from the flash bus |

## Verification
A phase counter loaded with the wrong value shows up in the same transfer at the ports. It changes the length of the strobe-low run or of the hold run, and it moves the done pulse by the same number of cycles. A wrong latched direction flag swaps which strobe toggles and whether dat_oe rises. Each of these is visible within one cycle of the phase where it goes wrong. A capture taken on the wrong edge shows in rd_data right after the read ends, because the bench gives bus_din a new random value every cycle.

// File: rtl/nss_pkg.sv
package nss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_STRB  = 2'd2,
      ST_HOLD  = 2'd3
   } nss_state_e;
endpackage

// File: rtl/nss_cfg_reg.sv
module nss_cfg_reg #(
   parameter int REG_W = 32,
   parameter int FW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic [FW-1:0]    spw,
   output logic [FW-1:0]    hold
);
   localparam int USED_W = 2 * FW;

   if (REG_W < USED_W) begin : g_bad_width
      $error("nss_cfg_reg: REG_W must hold both fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spw  <= '1;
         hold <= '1;
      end else if (we) begin
         spw  <= wdata[FW-1:0];
         hold <= wdata[USED_W-1:FW];
      end
   end

   if (REG_W > USED_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata[REG_W-1:USED_W];
      assign rdata     = {{(REG_W-USED_W){1'b0}}, hold, spw};
   end else begin : g_nopad
      assign rdata = {hold, spw};
   end

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[REG_W-1:FW] == {{(REG_W-USED_W){1'b0}}, hold});
endmodule

// File: rtl/nss_seq.sv
module nss_seq
   import nss_pkg::*;
#(
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          req_rd,
   input  logic [FW-1:0] cfg_spw,
   input  logic [FW-1:0] cfg_hold,
   output logic          load,
   output logic          cap_en,
   output logic          we_n,
   output logic          re_n,
   output logic          addr_oe,
   output logic          dat_oe,
   output logic          done
);
   localparam int CW = FW + 1;

   if (FW < 1) begin : g_bad_fw
      $error("nss_seq: FW must be at least 1");
   end

   nss_state_e    state;
   logic [CW-1:0] cnt;
   logic          rd_q;
   logic [FW-1:0] act_spw;
   logic [FW-1:0] act_hold;
   logic          last;

   function automatic logic [FW-1:0] fix_zero(input logic [FW-1:0] v);
      return (v == '0) ? FW'(1) : v;
   endfunction

   assign last   = (cnt == '0);
   assign load   = (state == ST_IDLE) && req;
   assign cap_en = (state == ST_STRB) && last && rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         rd_q     <= 1'b0;
         act_spw  <= '1;
         act_hold <= '1;
         done     <= 1'b0;
      end else begin
         done <= (state == ST_HOLD) && last;
         unique case (state)
            ST_IDLE: if (req) begin
               state    <= ST_SETUP;
               rd_q     <= req_rd;
               act_spw  <= fix_zero(cfg_spw);
               act_hold <= fix_zero(cfg_hold);
            end
            ST_SETUP: begin
               state <= ST_STRB;
               cnt   <= rd_q ? CW'(act_spw) : CW'(act_spw) - CW'(1);
            end
            ST_STRB: begin
               if (last) begin
                  state <= ST_HOLD;
                  cnt   <= CW'(act_hold);
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            ST_HOLD: begin
               if (last) state <= ST_IDLE;
               else      cnt   <= cnt - CW'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign we_n    = !((state == ST_STRB) && !rd_q);
   assign re_n    = !((state == ST_STRB) && rd_q);
   assign addr_oe = (state != ST_IDLE);
   assign dat_oe  = addr_oe && !rd_q;

   // length checker: consecutive strobe-low cycles
   logic [CW-1:0] lo_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               lo_run <= '0;
      else if (!we_n || !re_n)  lo_run <= lo_run + CW'(1);
      else                      lo_run <= '0;
   end

   // R3
   we_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (lo_run == CW'(act_spw)));
   // R4
   re_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(re_n) |-> (lo_run == CW'(act_spw) + CW'(1)));
   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   // R7
   strobe_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(we_n) || $fell(re_n)) |-> $past(addr_oe));
   // R8
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(addr_oe) |-> done);
   // R11
   dat_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_oe |-> (addr_oe && re_n));
endmodule

// File: rtl/nss_dpath.sv
module nss_dpath #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] req_wdata,
   input  logic          cap_en,
   input  logic [DW-1:0] bus_din,
   output logic [DW-1:0] bus_dout,
   output logic [DW-1:0] rd_data
);
   if (DW < 1) begin : g_bad_dw
      $error("nss_dpath: DW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_dout <= '0;
         rd_data  <= '0;
      end else begin
         if (load)   bus_dout <= req_wdata;
         if (cap_en) rd_data  <= bus_din;
      end
   end

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cap_en) |-> $stable(rd_data));
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
   parameter int REG_W = 32,
   parameter int FW    = 4,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             req,
   input  logic             req_rd,
   input  logic [DW-1:0]    req_wdata,
   output logic             done,
   output logic [DW-1:0]    rd_data,
   output logic             we_n,
   output logic             re_n,
   output logic             addr_oe,
   output logic             dat_oe,
   output logic [DW-1:0]    bus_dout,
   input  logic [DW-1:0]    bus_din
);
   logic [FW-1:0] spw;
   logic [FW-1:0] hold;
   logic          load;
   logic          cap_en;

   nss_cfg_reg #(.REG_W(REG_W), .FW(FW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .spw(spw), .hold(hold)
   );

   nss_seq #(.FW(FW)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd),
      .cfg_spw(spw), .cfg_hold(hold), .load(load), .cap_en(cap_en),
      .we_n(we_n), .re_n(re_n), .addr_oe(addr_oe), .dat_oe(dat_oe),
      .done(done)
   );

   nss_dpath #(.DW(DW)) u_dpath (
      .clk(clk), .rst_n(rst_n), .load(load), .req_wdata(req_wdata),
      .cap_en(cap_en), .bus_din(bus_din), .bus_dout(bus_dout),
      .rd_data(rd_data)
   );
endmodule

// File: tb/nand_strobe_gen_tb.sv
module nand_strobe_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req = 1'b0;
   logic        req_rd = 1'b0;
   logic [7:0]  req_wdata = '0;
   logic        done;
   logic [7:0]  rd_data;
   logic        we_n, re_n, addr_oe, dat_oe;
   logic [7:0]  bus_dout;
   logic [7:0]  bus_din = '0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   nand_strobe_gen u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req(req), .req_rd(req_rd),
      .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .we_n(we_n),
      .re_n(re_n), .addr_oe(addr_oe), .dat_oe(dat_oe),
      .bus_dout(bus_dout), .bus_din(bus_din)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic int eff(input int f);
      return (f == 0) ? 1 : f;
   endfunction

   task automatic wr_cfg(input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_xfer(input bit rd, input logic [7:0] wd, input int spw_f,
                           input int hold_f, input bit inject, input bit mcfg,
                           input logic [31:0] mval);
      int setup_n = 0, low_n = 0, hold_n = 0;
      bit seen_low = 0, got_done = 0, wrong_strb = 0, dout_ok = 1, doe_ok = 1;
      bit lo, other;
      logic [7:0] exp_rd = rd_data;
      @(negedge clk);
      req = 1'b1; req_rd = rd; req_wdata = wd;
      @(negedge clk);
      req = 1'b0; req_wdata = ~wd;
      for (int k = 0; k < 80; k++) begin
         if (k > 0) @(negedge clk);
         cfg_we = 1'b0; req = 1'b0;
         lo    = rd ? !re_n : !we_n;
         other = rd ? !we_n : !re_n;
         if (other) wrong_strb = 1;
         if (!addr_oe) begin
            got_done = done;
            break;
         end
         if (dat_oe != !rd) doe_ok = 0;
         if (!rd && bus_dout != wd) dout_ok = 0;
         bus_din = 8'($urandom);
         if (lo) begin
            low_n++; seen_low = 1; exp_rd = bus_din;
         end else if (!seen_low) setup_n++;
         else hold_n++;
         if (k == 0 && mcfg) begin cfg_we = 1'b1; cfg_wdata = mval; end
         if (k == 2 && inject) begin req = 1'b1; req_rd = !rd; req_wdata = 8'h5A; end
      end
      chk(setup_n == 1, "R7 setup cycles", setup_n, 1);
      chk(low_n == (rd ? eff(spw_f) + 1 : eff(spw_f)),
          rd ? "R4/R6 read strobe length" : "R3/R6 write strobe length",
          low_n, rd ? eff(spw_f) + 1 : eff(spw_f));
      chk(hold_n == eff(hold_f) + 1, "R5/R6 hold length", hold_n, eff(hold_f) + 1);
      chk(!wrong_strb, "R3/R4 other strobe high", wrong_strb, 0);
      chk(got_done, "R8 done at release", got_done, 1);
      chk(doe_ok, "R11 dat_oe window", doe_ok, 1);
      if (!rd) chk(dout_ok, "R3 write data on bus", dout_ok, 1);
      @(negedge clk);
      chk(!done && !addr_oe, "R8 done one cycle, no restart", {done, addr_oe}, 0);
      if (rd) chk(rd_data == exp_rd, "R9 captured read data", rd_data, exp_rd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cfg_rdata == 32'h0000_00FF, "R1 reset register", cfg_rdata, 32'hFF);
      chk(we_n && re_n && !addr_oe && !dat_oe && !done, "R1 reset outputs",
          {we_n, re_n, addr_oe, dat_oe, done}, 5'b11000);
      rst_n = 1'b1;
      @(negedge clk);
      // default fields 15/15
      run_xfer(1'b0, 8'hA5, 15, 15, 1'b0, 1'b0, 32'h0);
      // R2 reserved bits
      wr_cfg(32'hDEAD_BE5C);
      chk(cfg_rdata == 32'h0000_005C, "R2 reserved bits zero", cfg_rdata, 32'h5C);
      run_xfer(1'b1, 8'h00, 12, 5, 1'b0, 1'b0, 32'h0);
      // R6 zero fields
      wr_cfg(32'h0000_0000);
      chk(cfg_rdata == 32'h0, "R2 zero readback", cfg_rdata, 0);
      run_xfer(1'b0, 8'h3C, 0, 0, 1'b0, 1'b0, 32'h0);
      run_xfer(1'b1, 8'h00, 0, 0, 1'b0, 1'b0, 32'h0);
      // R8 request during running transfer is ignored
      wr_cfg(32'h0000_0021);
      run_xfer(1'b0, 8'hC3, 1, 2, 1'b1, 1'b0, 32'h0);
      run_xfer(1'b1, 8'h00, 1, 2, 1'b1, 1'b0, 32'h0);
      // R10 mid-transfer register write
      wr_cfg(32'h0000_0023);
      run_xfer(1'b0, 8'h96, 3, 2, 1'b0, 1'b1, 32'h0000_0017);
      chk(cfg_rdata == 32'h17, "R10 register updated", cfg_rdata, 32'h17);
      run_xfer(1'b0, 8'h69, 7, 1, 1'b0, 1'b0, 32'h0);
      // random mix
      for (int i = 0; i < 24; i++) begin
         int s, h;
         bit r;
         s = int'($urandom_range(0, 15));
         h = int'($urandom_range(0, 15));
         r = 1'($urandom);
         wr_cfg({24'($urandom), 4'(h), 4'(s)});
         chk(cfg_rdata == {24'h0, 4'(h), 4'(s)}, "R2 random readback",
             cfg_rdata, {24'h0, 4'(h), 4'(s)});
         run_xfer(r, 8'($urandom), s, h, (i % 3) == 0, (i % 4) == 1,
                  {24'h0, 8'($urandom)});
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule